// File: doc/BRIEF.md
# Early Tag Way Predictor

This block sits between the load/store queue stage and the access stage of a set-associative data cache. It keeps a small tag directory: for each set and way, a valid bit, the full tag and a short partial tag made of the low tag bits. In the queue stage it matches the partial tag of the incoming request against every valid way of the indexed set. One cycle later, in the access stage, it presents a registered way-enable vector. When exactly one way matched early, only that way is enabled. When no way or several ways matched, all ways are enabled.

In the access stage the block checks the full tag. If an early prediction turns out wrong, it raises a mispredict flag for one cycle and then repeats the access with every way enabled. During that cycle the queue-stage request is not taken, so the queue must hold it. Fills and invalidations write the full tag, the partial tag and the valid bit on the same clock edge. The data ways and the replacement policy belong to the surrounding cache.

Top module: `early_tag_way_predictor`

## Requirements
- R1: While reset is low, and on the first cycle after it, acc_valid, way_en, early_hit, hit and mispredict are all zero, and every way of every set is invalid.
- R2: A request taken in the queue stage appears in the access stage on the next cycle with acc_valid high. If exactly one valid way of set lsq_set has its stored partial tag equal to lsq_tag[5:0], way_en is one-hot on that way (bit n means way n) and early_hit is 1.
- R3: If no valid way of the indexed set matches the partial tag, way_en is all ones and early_hit is 0.
- R4: If two or more valid ways match the partial tag, way_en is all ones and early_hit is 0.
- R5: With early_hit high, when the predicted way holds the full 20-bit request tag, hit is 1 and mispredict is 0.
- R6: With early_hit high, when the predicted way does not hold the full tag, mispredict is 1 and hit is 0 for that one cycle. The next cycle is a replay of the same request with acc_valid 1, way_en all ones and early_hit 0. The queue-stage request present during the mispredict cycle is not taken and must be held.
- R7: When early_hit is 0 with acc_valid high, hit is 1 exactly when some valid way of the set holds the full request tag.
- R8: A fill with fill_valid=1 stores the tag, sets the valid bit and sets the partial tag to fill_tag[5:0] in one edge. A request taken on the next edge sees the new entry.
- R9: A fill with fill_valid=0 clears the valid bit of the addressed way. That way then takes part in neither the partial match nor the full match.
- R10: In a cycle with no access (no request taken and no replay), acc_valid, way_en, early_hit, hit and mispredict are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lsq_valid | input | 1 | Queue-stage request present |
| lsq_set | input | 6 | Set index of the request |
| lsq_tag | input | 20 | Full tag of the request |
| fill_en | input | 1 | Write one directory entry |
| fill_valid | input | 1 | 1 installs the tag, 0 invalidates the way |
| fill_set | input | 6 | Set index of the write |
| fill_way | input | 2 | Way number of the write |
| fill_tag | input | 20 | Tag to install |
| acc_valid | output | 1 | Access-stage cycle is active |
| way_en | output | 4 | Data-way enables for the access stage |
| early_hit | output | 1 | Access uses a single predicted way |
| hit | output | 1 | Full tag found for this access |
| mispredict | output | 1 | Predicted way was wrong, replay follows |

## Verification
The assertions assume that the queue holds its request steady during a mispredict cycle. They also assume that fills do not target a set while a request to that set is between the queue and access stages, because then the early and the full compares would see different contents. The stimulus keeps every fill apart from in-flight requests. After any request that the bench's own model expects to mispredict, the stimulus holds the following request for an extra cycle. Partial-tag collisions are arranged on purpose by picking tags whose low six bits agree but whose upper bits differ.

// File: rtl/etwp_pkg.sv
// Package: default geometry of the early tag way predictor.
// Assumes: every module takes these values as parameter defaults only.
package etwp_pkg;
    localparam int unsigned DEF_WAYS   = 4;
    localparam int unsigned DEF_SETS   = 64;
    localparam int unsigned DEF_TAG_W  = 20;
    localparam int unsigned DEF_PTAG_W = 6;
endpackage

// File: rtl/etwp_tag_store.sv
// Module: tag directory, one entry per set and way (valid, full tag, partial tag).
// Assumes: one write port; two combinational read ports, one for the queue
// stage (partial tags) and one for the access stage (full tags).
module etwp_tag_store #(
    parameter int unsigned WAYS   = etwp_pkg::DEF_WAYS,
    parameter int unsigned SETS   = etwp_pkg::DEF_SETS,
    parameter int unsigned TAG_W  = etwp_pkg::DEF_TAG_W,
    parameter int unsigned PTAG_W = etwp_pkg::DEF_PTAG_W,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_en,
    input  logic                         fill_valid,
    input  logic [IDX_W-1:0]             fill_set,
    input  logic [WAY_W-1:0]             fill_way,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [IDX_W-1:0]             q_set,
    output logic [WAYS-1:0]              q_vld,
    output logic [WAYS-1:0][PTAG_W-1:0]  q_ptag,
    input  logic [IDX_W-1:0]             a_set,
    output logic [WAYS-1:0]              a_vld,
    output logic [WAYS-1:0][TAG_W-1:0]   a_tag
);
    logic [WAYS-1:0]    vld  [SETS];
    logic [TAG_W-1:0]   ftag [SETS][WAYS];
    logic [PTAG_W-1:0]  ptag [SETS][WAYS];

    // Valid bits: cleared by reset, set or cleared by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else if (fill_en) begin
            vld[fill_set][fill_way] <= fill_valid;
        end
    end

    // Full and partial tags are written together on an installing fill.
    always_ff @(posedge clk) begin
        if (fill_en && fill_valid) begin
            ftag[fill_set][fill_way] <= fill_tag;
            ptag[fill_set][fill_way] <= fill_tag[PTAG_W-1:0];
        end
    end

    // Read ports, one lane per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign q_vld[w]  = vld[q_set][w];
        assign q_ptag[w] = ptag[q_set][w];
        assign a_vld[w]  = vld[a_set][w];
        assign a_tag[w]  = ftag[a_set][w];
    end

    p_fill_install_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && fill_valid |=> vld[$past(fill_set)][$past(fill_way)]
            && ptag[$past(fill_set)][$past(fill_way)] == $past(fill_tag[PTAG_W-1:0]));

    p_fill_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !fill_valid |=> !vld[$past(fill_set)][$past(fill_way)]);
endmodule

// File: rtl/etwp_partial_match.sv
// Module: queue-stage partial tag compare and way-enable choice.
// Assumes: inputs are the valid bits and partial tags of one set; pure logic.
module etwp_partial_match #(
    parameter int unsigned WAYS   = etwp_pkg::DEF_WAYS,
    parameter int unsigned PTAG_W = etwp_pkg::DEF_PTAG_W
) (
    input  logic [WAYS-1:0]              vld,
    input  logic [WAYS-1:0][PTAG_W-1:0]  ptag,
    input  logic [PTAG_W-1:0]            key,
    output logic [WAYS-1:0]              en_next,
    output logic                         unique_hit
);
    logic [WAYS-1:0] match;

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (ptag[w] == key);
    end

    // A single match predicts one way; anything else enables all ways.
    always_comb begin
        unique_hit = $onehot(match);
        en_next    = unique_hit ? match : '1;
    end
endmodule

// File: rtl/etwp_full_check.sv
// Module: access-stage full tag check and mispredict decision.
// Assumes: inputs come from the access-stage registers and the directory read
// port for the registered set; pure logic.
module etwp_full_check #(
    parameter int unsigned WAYS  = etwp_pkg::DEF_WAYS,
    parameter int unsigned TAG_W = etwp_pkg::DEF_TAG_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        early,
    input  logic [WAYS-1:0]             way_en,
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic                        mispredict
);
    logic [WAYS-1:0] full_match;
    logic            pred_ok;

    // Full comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign full_match[w] = vld[w] && (tags[w] == key);
    end

    // Hit and mispredict from either the predicted way or all ways.
    always_comb begin
        pred_ok    = |(full_match & way_en);
        mispredict = acc_valid && early && !pred_ok;
        hit        = acc_valid && (early ? pred_ok : |full_match);
    end

    p_hit_excl_mispredict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && mispredict));

    p_mispredict_needs_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> early && acc_valid);
endmodule

// File: rtl/early_tag_way_predictor.sv
// Module: top of the early tag way predictor.
// Assumes: the queue holds its request while mispredict is high; fills do not
// hit a set that has a request in flight between queue and access stage.
module early_tag_way_predictor #(
    parameter int unsigned WAYS   = etwp_pkg::DEF_WAYS,
    parameter int unsigned SETS   = etwp_pkg::DEF_SETS,
    parameter int unsigned TAG_W  = etwp_pkg::DEF_TAG_W,
    parameter int unsigned PTAG_W = etwp_pkg::DEF_PTAG_W,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsq_valid,
    input  logic [IDX_W-1:0]  lsq_set,
    input  logic [TAG_W-1:0]  lsq_tag,
    input  logic              fill_en,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              acc_valid,
    output logic [WAYS-1:0]   way_en,
    output logic              early_hit,
    output logic              hit,
    output logic              mispredict
);
    logic [WAYS-1:0]              q_vld;
    logic [WAYS-1:0][PTAG_W-1:0]  q_ptag;
    logic [WAYS-1:0]              a_vld;
    logic [WAYS-1:0][TAG_W-1:0]   a_tag_rd;
    logic [WAYS-1:0]              en_next;
    logic                         uniq;
    logic [IDX_W-1:0]             a_set;
    logic [TAG_W-1:0]             a_key;

    etwp_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .PTAG_W(PTAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_way(fill_way), .fill_tag(fill_tag),
        .q_set(lsq_set), .q_vld(q_vld), .q_ptag(q_ptag),
        .a_set(a_set), .a_vld(a_vld), .a_tag(a_tag_rd)
    );

    etwp_partial_match #(.WAYS(WAYS), .PTAG_W(PTAG_W)) u_pmatch (
        .vld(q_vld), .ptag(q_ptag), .key(lsq_tag[PTAG_W-1:0]),
        .en_next(en_next), .unique_hit(uniq)
    );

    // Access-stage registers: take a new request, or replay after a mispredict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            way_en    <= '0;
            early_hit <= 1'b0;
            a_set     <= '0;
            a_key     <= '0;
        end else if (mispredict) begin
            acc_valid <= 1'b1;
            way_en    <= '1;
            early_hit <= 1'b0;
        end else begin
            acc_valid <= lsq_valid;
            way_en    <= lsq_valid ? en_next : '0;
            early_hit <= lsq_valid && uniq;
            if (lsq_valid) begin
                a_set <= lsq_set;
                a_key <= lsq_tag;
            end
        end
    end

    etwp_full_check #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fcheck (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .early(early_hit), .way_en(way_en),
        .vld(a_vld), .tags(a_tag_rd), .key(a_key),
        .hit(hit), .mispredict(mispredict)
    );

    p_early_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        early_hit |-> $onehot(way_en) && acc_valid);

    p_fallback_all_ways_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !early_hit |-> &way_en);

    p_mispredict_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> !mispredict);

    p_replay_all_ways_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> acc_valid && (&way_en) && !early_hit);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> way_en == '0 && !hit && !mispredict && !early_hit);
endmodule

// File: tb/sim_early_tag_way_predictor.sv
module sim_early_tag_way_predictor;
    localparam int WAYS = 4;
    localparam int SETS = 64;
    localparam int TAG_W = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lsq_valid = 1'b0;
    logic [5:0]  lsq_set = '0;
    logic [19:0] lsq_tag = '0;
    logic        fill_en = 1'b0;
    logic        fill_valid = 1'b0;
    logic [5:0]  fill_set = '0;
    logic [1:0]  fill_way = '0;
    logic [19:0] fill_tag = '0;
    logic        acc_valid;
    logic [3:0]  way_en;
    logic        early_hit;
    logic        hit;
    logic        mispredict;

    int n_checks = 0;
    int n_fail = 0;
    bit pending_mp = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] en;
        logic       early;
        logic       hit;
        logic       mp;
        string      req;
    } exp_t;
    exp_t sb[$];

    logic        m_vld [SETS][WAYS];
    logic [19:0] m_tag [SETS][WAYS];

    always #2.5 clk = ~clk;

    early_tag_way_predictor u0 (
        .clk(clk), .rst_n(rst_n), .lsq_valid(lsq_valid), .lsq_set(lsq_set),
        .lsq_tag(lsq_tag), .fill_en(fill_en), .fill_valid(fill_valid),
        .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .acc_valid(acc_valid), .way_en(way_en), .early_hit(early_hit),
        .hit(hit), .mispredict(mispredict)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int s, input int w, input logic [19:0] t, input logic v);
        @(negedge clk);
        lsq_valid = 1'b0;
        fill_en = 1'b1; fill_valid = v; fill_set = 6'(s); fill_way = 2'(w); fill_tag = t;
        m_vld[s][w] = v;
        if (v) m_tag[s][w] = t;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Driver: compute expected items from the model and push them, then drive.
    task automatic lookup(input int s, input logic [19:0] t, input string req);
        exp_t e;
        logic [3:0] pm;
        logic any_full;
        bit hold;
        pm = '0; any_full = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (m_vld[s][w] && m_tag[s][w][5:0] == t[5:0]) pm[w] = 1'b1;
            if (m_vld[s][w] && m_tag[s][w] == t) any_full = 1'b1;
        end
        e.req = req;
        if ($countones(pm) == 1) begin
            e.en = pm; e.early = 1'b1;
            e.hit = 1'b0;
            for (int w = 0; w < WAYS; w++) if (pm[w] && m_tag[s][w] == t) e.hit = 1'b1;
            e.mp = !e.hit;
        end else begin
            e.en = 4'hF; e.early = 1'b0; e.hit = any_full; e.mp = 1'b0;
        end
        sb.push_back(e);
        if (e.mp) begin
            exp_t r;
            r.en = 4'hF; r.early = 1'b0; r.hit = any_full; r.mp = 1'b0; r.req = "R6 replay";
            sb.push_back(r);
        end
        if (!(hold = pending_mp)) ;
        @(negedge clk);
        lsq_valid = 1'b1; lsq_set = 6'(s); lsq_tag = t;
        if (hold) @(negedge clk);
        pending_mp = e.mp;
    endtask

    task automatic idle();
        @(negedge clk);
        lsq_valid = 1'b0;
        if (pending_mp) @(negedge clk);
        pending_mp = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop and compare on every active access-stage cycle (R10 when idle).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (acc_valid) begin
                if (sb.size() == 0) begin
                    check("R10", "unexpected access", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, "way_en", int'(way_en), int'(e.en));
                    check(e.req, "early_hit", int'(early_hit), int'(e.early));
                    check(e.req, "hit", int'(hit), int'(e.hit));
                    check(e.req, "mispredict", int'(mispredict), int'(e.mp));
                end
            end else begin
                check("R10", "idle outputs", int'({way_en, early_hit, hit, mispredict}), 0);
            end
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 1'b0; m_tag[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset", int'({acc_valid, way_en, early_hit, hit, mispredict}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "outputs after reset", int'({acc_valid, way_en, early_hit, hit, mispredict}), 0);
        // R1 R3: empty set, no partial match, all ways, miss
        lookup(9, 20'h12345, "R1 R3 empty set");
        idle();
        // R8: install entries then look them up
        fill(5, 0, 20'h12345, 1'b1);
        fill(5, 1, 20'h00A47, 1'b1);
        lookup(5, 20'h12345, "R2 R5 R8 way0");
        lookup(5, 20'h00A47, "R2 R5 way1");
        // R6: partial tag 07 matches way1, full tag differs; next request held
        lookup(5, 20'h3FF07, "R6 mispredict");
        lookup(5, 20'h00A47, "R6 held request");
        lookup(5, 20'h00011, "R3 no match");
        idle();
        // R4 R7: two ways share partial tag 05
        fill(5, 2, 20'h99905, 1'b1);
        lookup(5, 20'h99905, "R4 R7 multi hit");
        lookup(5, 20'hABC05, "R4 R7 multi miss");
        idle();
        // R9: invalidate way0, then 12345 predicts way2 and mispredicts
        fill(5, 0, 20'h0, 1'b0);
        lookup(5, 20'h99905, "R9 R2 unique after clear");
        lookup(5, 20'h12345, "R9 R6 stale tag");
        idle();
        // R8: fill followed at once by a lookup of the same entry
        fill(63, 3, 20'hFFFFF, 1'b1);
        lookup(63, 20'hFFFFF, "R8 R2 way3");
        lookup(63, 20'h0003F, "R6 way3 partial only");
        lookup(0, 20'h0003F, "R3 set0");
        idle();
        repeat (3) @(negedge clk);
        check("R10", "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule